// File: doc/BRIEF.md
# Flow-Through Burst Synchronous SRAM

A synchronous static memory whose data word is split into four byte lanes. Address, strobes, chip enables and write controls are captured on the rising clock edge. A new access begins when either of two address strobes is low: a processor-side strobe that always starts a read, or a controller-side strobe that starts a read or a write depending on the write enables seen at that edge. On later edges an advance input steps a two-bit burst counter. The counter moves only the two low address bits, in linear or interleaved order, and never the upper bits.

Reads are flow-through. The word at the current address drives the read data port straight from the array during the cycle that follows the edge which set that address. No output register sits in the path. An active-low output enable gates the drive-enable output combinationally, without waiting for a clock. A sleep input stops all access while it is high. The common data bus is shown as a separate write-data input, read-data output and drive-enable output, which an outer pad ring combines into one tristate bus.

Top module: `fts_sram`

## Requirements
- R1: After the edge that starts a read at address A, and within the same cycle, `dout` equals the stored word at A and `dq_drive` is 1 while `oe_n` is 0.
- R2: `oe_n` acts without a clock. While it is 1, `dq_drive` is 0. When it returns to 0 during an active read, `dq_drive` goes back to 1 in the same cycle.
- R3: A start with `adsp_n` low is always a read and writes nothing, whatever the write controls are. It takes priority over `adsc_n` when both strobes are low.
- R4: A start with `adsc_n` low (and `adsp_n` high), `gw_n` high and `bwe_n` low writes `din` into each lane k for which `bw_n[k]` is 0. Lane k occupies bits [k*LANE_W +: LANE_W]. All other lanes keep their contents.
- R5: When `gw_n` is 0 on a write edge, all four lanes are written, whatever `bwe_n` and `bw_n` are.
- R6: The device is selected when `ce0_n`=0, `ce1`=1 and `ce2_n`=0. A start with any other combination ends the access. It writes nothing, and `dq_drive` is 0 on the following cycle.
- R7: On an edge with both strobes high, an active access and `adv_n` low, the burst counter advances by one. Any write on that edge goes to the new address. The new word is read out in that cycle.
- R8: With `ilv` = 0 at the start edge (linear order), the low address bits of burst step c are (start + c) mod 4.
- R9: With `ilv` = 1 at the start edge (interleaved order), the low address bits of step c are start XOR c.
- R10: The burst wraps inside its aligned 4-word block. The upper address bits never change during a burst.
- R11: On an edge with both strobes high, an active access and `adv_n` high, the address is held. Any read output stays on the same word.
- R12: An edge with `zz` high performs no access and no write, and it ends any burst. `dq_drive` is 0 afterwards.
- R13: While reset is low, and after it is released until the first start, `dq_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the access state |
| addr | input | ADDR_W | Word address loaded on a start |
| adsp_n | input | 1 | Processor strobe, active low; starts a read |
| adsc_n | input | 1 | Controller strobe, active low; starts a read or a write |
| adv_n | input | 1 | Burst advance, active low |
| ilv | input | 1 | Burst order: 0 linear, 1 interleaved; sampled on a start |
| gw_n | input | 1 | Global write, active low; writes all lanes |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| bw_n | input | 4 | Per-lane write enables, active low, bit k is lane k |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low, combinational |
| zz | input | 1 | Sleep; blocks access while high |
| din | input | 4*LANE_W | Write data |
| dout | output | 4*LANE_W | Flow-through read data |
| dq_drive | output | 1 | Bus drive enable for the read data |

## Verification
Every access result is due in the cycle that directly follows the edge that caused it. Inputs change on the falling edge and are captured on the next rising edge. The bench reads `dout` and `dq_drive` on the falling edge after that rising edge, so one rising edge lies between each stimulus and its check. The output-enable checks are the exception: they change `oe_n` in the middle of a cycle and sample one time unit later, with no clock edge in between. A write is checked by starting a read of the same word on a later edge.

// File: rtl/fts_sram.sv
module fts_sram #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  localparam int LANES  = 4,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              ilv,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              ce0_n,
  input  logic              ce1,
  input  logic              ce2_n,
  input  logic              oe_n,
  input  logic              zz,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dq_drive
);

  function automatic logic [1:0] burst_lo(input logic [1:0] first,
                                          input logic [1:0] step,
                                          input logic       inter);
    return inter ? (first ^ step) : (first + step);
  endfunction

  logic              act_q, wr_q, ilv_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;

  logic sel, start_p, start_c, start, cont, step;
  logic [1:0]        cnt_nx;
  logic [LANES-1:0]  lanes_req, wlanes;
  logic [ADDR_W-1:0] acc_addr, cur_addr;

  assign sel     = !ce0_n && ce1 && !ce2_n;
  assign start_p = !adsp_n;
  assign start_c = adsp_n && !adsc_n;
  assign start   = start_p || start_c;
  assign cont    = !zz && !start && act_q;
  assign step    = cont && !adv_n;
  assign cnt_nx  = step ? cnt_q + 2'd1 : cnt_q;

  assign lanes_req = !gw_n ? {LANES{1'b1}} : (!bwe_n ? ~bw_n : {LANES{1'b0}});

  always_comb begin
    wlanes = '0;
    if (!zz && ((start_c && sel) || cont))
      wlanes = lanes_req;
  end

  assign acc_addr = start ? addr
                          : {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], cnt_nx, ilv_q)};
  assign cur_addr = {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], cnt_q, ilv_q)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      ilv_q  <= 1'b0;
      base_q <= '0;
      cnt_q  <= 2'd0;
    end else if (zz) begin
      act_q <= 1'b0;
      wr_q  <= 1'b0;
    end else if (start) begin
      act_q  <= sel;
      base_q <= addr;
      ilv_q  <= ilv;
      cnt_q  <= 2'd0;
      wr_q   <= sel && start_c && (|lanes_req);
    end else if (act_q) begin
      cnt_q <= cnt_nx;
      wr_q  <= |lanes_req;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (wlanes[k])
        bank[acc_addr] <= din[k*LANE_W +: LANE_W];
    end
    assign dout[k*LANE_W +: LANE_W] = bank[cur_addr];
  end

  assign dq_drive = act_q && !wr_q && !oe_n;

  AST_ADSP_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (start_p && sel && !zz) |=> (act_q && !wr_q)); // R3
  AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sel && !zz) |=> !act_q); // R6
  AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    zz |=> !dq_drive); // R12
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ilv_q) |=> (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1)); // R8
  AST_INTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ilv_q) |=> ((cur_addr[1:0] ^ base_q[1:0]) == $past(cnt_q) + 2'd1)); // R9
  AST_BLOCK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    cont |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]))); // R10
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && adv_n) |=> $stable(cur_addr)); // R11

endmodule

// File: tb/fts_sram_tb.sv
module fts_sram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int LW = 9;
  localparam int DW = 4 * LW;
  localparam logic [AW-1:0] BASE = 8'h44;

  // {ilv, start, step1, step2, step3}
  localparam logic [8:0] VEC [8] = '{
    {1'b0, 2'd0, 2'd1, 2'd2, 2'd3},
    {1'b0, 2'd1, 2'd2, 2'd3, 2'd0},
    {1'b0, 2'd2, 2'd3, 2'd0, 2'd1},
    {1'b0, 2'd3, 2'd0, 2'd1, 2'd2},
    {1'b1, 2'd0, 2'd1, 2'd2, 2'd3},
    {1'b1, 2'd1, 2'd0, 2'd3, 2'd2},
    {1'b1, 2'd2, 2'd3, 2'd0, 2'd1},
    {1'b1, 2'd3, 2'd2, 2'd1, 2'd0}
  };

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr;
  logic adsp_n, adsc_n, adv_n, ilv, gw_n, bwe_n, ce0_n, ce1, ce2_n, oe_n, zz;
  logic [3:0] bw_n;
  logic [DW-1:0] din, dout;
  logic dq_drive;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fts_sram #(.ADDR_W(AW), .LANE_W(LW)) u_dut (
    .clk, .rst_n, .addr, .adsp_n, .adsc_n, .adv_n, .ilv, .gw_n, .bwe_n, .bw_n,
    .ce0_n, .ce1, .ce2_n, .oe_n, .zz, .din, .dout, .dq_drive);

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {4'hA, a, ~a, a ^ 8'h5A, a + 8'd3};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 4'hF;
    ce0_n = 0; ce1 = 1; ce2_n = 0; zz = 0;
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic gwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    adsc_n = 0; addr = a; din = d; gw_n = 0;
    cyc(); idle();
  endtask

  task automatic pread(input logic [AW-1:0] a);
    adsp_n = 0; addr = a;
    cyc(); idle();
  endtask

  logic [DW-1:0] expv;

  initial begin
    idle(); addr = '0; din = '0; ilv = 0; oe_n = 0;
    repeat (2) cyc();
    chk("R13 drive in reset", {35'd0, dq_drive}, 36'd0);
    rst_n = 1;
    cyc();
    chk("R13 drive after reset", {35'd0, dq_drive}, 36'd0);

    for (int a = 'h40; a < 'h4C; a++) gwrite(AW'(a), pat(AW'(a)));
    for (int a = 'h10; a < 'h14; a++) gwrite(AW'(a), pat(AW'(a)));

    for (int i = 0; i < 8; i++) begin
      ilv = VEC[i][8];
      pread(BASE | AW'(VEC[i][7:6]));
      ilv = ~VEC[i][8];
      chk("R1 flow-through data", dout, pat(BASE | AW'(VEC[i][7:6])));
      chk("R1 drive", {35'd0, dq_drive}, 36'd1);
      for (int k = 1; k < 4; k++) begin
        adv_n = 0; cyc(); adv_n = 1;
        chk(VEC[i][8] ? "R9 R7 R10 interleaved step" : "R8 R7 R10 linear step",
            dout, pat(BASE | AW'(VEC[i][6 - 2*k +: 2])));
      end
      ilv = 0;
    end

    pread(8'h45);
    cyc();
    chk("R11 hold", dout, pat(8'h45));
    #1 oe_n = 1; #1;
    chk("R2 oe off", {35'd0, dq_drive}, 36'd0);
    oe_n = 0; #1;
    chk("R2 oe on", {35'd0, dq_drive}, 36'd1);
    @(negedge clk);

    adsp_n = 0; adsc_n = 0; gw_n = 0; addr = 8'h13; din = '1;
    cyc(); idle();
    chk("R3 adsp read drive", {35'd0, dq_drive}, 36'd1);
    chk("R3 adsp read data", dout, pat(8'h13));

    adsc_n = 0; addr = 8'h10; din = 36'h123456789; bwe_n = 0; bw_n = 4'b1010;
    cyc(); idle();
    expv = pat(8'h10);
    expv[0 +: LW] = din[0 +: LW];
    expv[2*LW +: LW] = din[2*LW +: LW];
    pread(8'h10);
    chk("R4 byte write", dout, expv);

    adsc_n = 0; addr = 8'h10; din = 36'h0FEDCBA98; gw_n = 0; bwe_n = 0; bw_n = 4'hF;
    cyc(); idle();
    pread(8'h10);
    chk("R5 global write", dout, 36'h0FEDCBA98);

    pread(8'h11);
    adsc_n = 0; addr = 8'h11; gw_n = 0; din = '0; ce1 = 0;
    cyc(); idle();
    chk("R6 deselect drive", {35'd0, dq_drive}, 36'd0);
    pread(8'h11);
    chk("R6 no write when deselected", dout, pat(8'h11));
    adsp_n = 0; addr = 8'h11; ce2_n = 1;
    cyc(); idle();
    chk("R6 ce2 deselect", {35'd0, dq_drive}, 36'd0);

    pread(8'h12);
    zz = 1; adsc_n = 0; addr = 8'h12; gw_n = 0; din = '0;
    cyc(); idle();
    chk("R12 sleep drive", {35'd0, dq_drive}, 36'd0);
    pread(8'h12);
    chk("R12 no write in sleep", dout, pat(8'h12));

    adsc_n = 0; addr = 8'h20; gw_n = 0; din = 36'h111111111;
    cyc();
    adsc_n = 1; adv_n = 0; din = 36'h222222222;
    cyc(); idle();
    pread(8'h21);
    chk("R7 burst write step", dout, 36'h222222222);
    adsc_n = 0; addr = 8'h20;
    cyc(); idle();
    chk("R7 first burst word", dout, 36'h111111111);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule